// File: doc/BRIEF.md
# Halt-State Sequencer with Interrupt Wake

This block sits inside a small 8-bit processor core and owns the halted condition. When the instruction decoder reports a halt opcode, the block records the address of the next instruction and parks the core. While parked, the core behaves as if it were running empty fetch cycles. It makes no program progress and touches no memory. The only ways out are an accepted interrupt or reset.

While parked, the block reports the condition in three ways. An active-low pin stays low for the whole wait. A status-word bit marks the first clock of each pseudo-fetch loop. A two-bit status code reads zero, and the bus drivers are turned off at the same time. When a wake source is accepted, the block starts the vectoring sequence. It raises a one-cycle push request that carries the saved return address, and it signals when the vector sequence ends. The length of that sequence depends on the selected interrupt mode.

The pseudo-fetch loop lasts four clocks, and wake sources are sampled only on its last clock. This keeps the delay from a wake source to the start of vectoring at four cycles or fewer.

Top module: `halt_wake_ctrl`

## Requirements
- R1: A `halt_dec` pulse while running sets `halt_n` low on the next clock. `halt_n` stays low until a wake is accepted or reset is asserted.
- R2: While `halt_n` is low, `bus_en` is 0 and `s_code` is 2'b00. Otherwise `bus_en` is 1 and `s_code` is 2'b11.
- R3: `stat_word` bit 3 is 1 only in the first clock of each 4-clock halted loop. The loop starts in the clock after entry. All other `stat_word` bits are always 0, and bit 3 is 0 while running.
- R4: With `ie` = 0, a maskable request (`irq_req`) does not wake the core, however long it is held.
- R5: `nmi_req` wakes the core whatever the value of `ie`.
- R6: Wake sources are sampled in the last clock of the loop. If a source is applied k clocks after entry (k = 0..3), `ack_start` appears 4-k clocks later, so the delay is never more than 4 clocks.
- R7: `halt_n` is high in the cycle in which `ack_start` is high.
- R8: Each wake produces exactly one `push_req` pulse, in the `ack_start` cycle. During that pulse, `push_addr` equals the `pc_next` value captured with `halt_dec`.
- R9: `vec_done` comes on the Nth cycle of the vector sequence, counting the `ack_start` cycle as cycle 1. N is 11, 13 or 19 for `im_sel` = 0, 1 or 2, and 11 for a non-maskable wake.
- R10: If both sources are pending at the sample clock, the non-maskable one wins and uses its own length.
- R11: Asserting `rst_n` low forces `halt_n` high and `bus_en` high at once, without waiting for a clock.
- R12: While running, `irq_req` and `nmi_req` start no vector sequence from this block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_dec | input | 1 | Decoder pulse: halt opcode fetched |
| pc_next | input | 16 | Address of the instruction after the halt opcode |
| ie | input | 1 | Maskable interrupt enable flag |
| irq_req | input | 1 | Maskable interrupt request (level) |
| nmi_req | input | 1 | Non-maskable interrupt request (level) |
| im_sel | input | 2 | Interrupt mode select: 0, 1 or 2 (3 acts as 2) |
| halt_n | output | 1 | Low while the core waits in the halted state |
| stat_word | output | 8 | Status byte; bit 3 flags the first clock of a halted loop |
| s_code | output | 2 | Two-bit status: 00 halted, 11 otherwise |
| bus_en | output | 1 | Enable for the data, address and control drivers; 0 means tristated |
| ack_start | output | 1 | One-cycle pulse when the vector sequence begins |
| push_req | output | 1 | One-cycle request to push the return address |
| push_addr | output | 16 | Return address carried with the push request |
| vec_done | output | 1 | Pulse in the last cycle of the vector sequence |

## Verification
The bench uses the default parameters: a 16-bit address, a 4-clock halted loop, and sequence lengths of 11, 13 and 19 for the three modes and 11 for the non-maskable wake. With these values it applies a wake at every position inside the loop, so each delay from 4 down to 1 clock is observed. It also runs each mode length to completion and checks that the non-maskable length is used even when mode 2 is selected. Holding a masked request for several full loops shows that a masked request is never accepted, whatever its position in the loop.

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl #(
  parameter int AW      = 16,
  parameter int LOOP    = 4,
  parameter int LAT_IM0 = 11,
  parameter int LAT_IM1 = 13,
  parameter int LAT_IM2 = 19,
  parameter int LAT_NMI = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          halt_dec,
  input  logic [AW-1:0] pc_next,
  input  logic          ie,
  input  logic          irq_req,
  input  logic          nmi_req,
  input  logic [1:0]    im_sel,
  output logic          halt_n,
  output logic [7:0]    stat_word,
  output logic [1:0]    s_code,
  output logic          bus_en,
  output logic          ack_start,
  output logic          push_req,
  output logic [AW-1:0] push_addr,
  output logic          vec_done
);
  localparam int TW   = (LOOP > 2) ? $clog2(LOOP) : 1;
  localparam int LM01 = (LAT_IM0 > LAT_IM1) ? LAT_IM0 : LAT_IM1;
  localparam int LM2N = (LAT_IM2 > LAT_NMI) ? LAT_IM2 : LAT_NMI;
  localparam int LMAX = (LM01 > LM2N) ? LM01 : LM2N;
  localparam int VW   = $clog2(LMAX + 1);

  typedef enum logic [1:0] {RUN, PARK, VECT} st_t;

  st_t           st;
  logic [TW-1:0] tcnt;
  logic [VW-1:0] vcnt;
  logic [VW-1:0] lat_sel;
  logic [AW-1:0] ret;
  logic          first;

  wire parked    = (st == PARK);
  wire wake      = nmi_req | (irq_req & ie);
  wire loop_last = parked && (tcnt == TW'(LOOP - 1));

  always_comb begin
    if (nmi_req)            lat_sel = VW'(LAT_NMI);
    else if (im_sel == 2'd0) lat_sel = VW'(LAT_IM0);
    else if (im_sel == 2'd1) lat_sel = VW'(LAT_IM1);
    else                     lat_sel = VW'(LAT_IM2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= RUN;
      tcnt  <= '0;
      vcnt  <= '0;
      ret   <= '0;
      first <= 1'b0;
    end else begin
      first <= 1'b0;
      case (st)
        RUN: if (halt_dec) begin
          st   <= PARK;
          tcnt <= '0;
          ret  <= pc_next;
        end
        PARK: begin
          if (loop_last && wake) begin
            st    <= VECT;
            vcnt  <= lat_sel - 1'b1;
            first <= 1'b1;
          end else begin
            tcnt <= loop_last ? '0 : tcnt + 1'b1;
          end
        end
        VECT: begin
          if (vcnt == '0) st <= RUN;
          else            vcnt <= vcnt - 1'b1;
        end
        default: st <= RUN;
      endcase
    end
  end

  assign halt_n    = ~parked;
  assign bus_en    = ~parked;
  assign s_code    = parked ? 2'b00 : 2'b11;
  assign stat_word = {4'b0000, parked && (tcnt == '0), 3'b000};
  assign ack_start = first;
  assign push_req  = first;
  assign push_addr = ret;
  assign vec_done  = (st == VECT) && (vcnt == '0);
endmodule

module halt_wake_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ie,
  input logic       irq_req,
  input logic       nmi_req,
  input logic       halt_n,
  input logic       bus_en,
  input logic [1:0] s_code,
  input logic       ack_start,
  input logic       push_req
);
  logic [3:0] wcnt;
  wire        wake_c = nmi_req | (irq_req & ie);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wcnt <= '0;
    else if (!halt_n && wake_c) wcnt <= wcnt + 1'b1;
    else wcnt <= '0;
  end

  p_quiet_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !halt_n |-> (!bus_en && s_code == 2'b00));
  p_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_start |-> $past(nmi_req || (irq_req && ie)));
  p_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= 4'd4);
  p_pin_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_start |-> halt_n);
  p_one_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push_req |=> !push_req);
  p_from_park_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ack_start |-> $past(!halt_n));
endmodule

bind halt_wake_ctrl halt_wake_chk u_chk (.*);

// File: tb/halt_wake_ctrl_bench.sv
module halt_wake_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        halt_dec = 1'b0;
  logic [15:0] pc_next = 16'h0000;
  logic        ie = 1'b0;
  logic        irq_req = 1'b0;
  logic        nmi_req = 1'b0;
  logic [1:0]  im_sel = 2'd0;
  logic        halt_n;
  logic [7:0]  stat_word;
  logic [1:0]  s_code;
  logic        bus_en;
  logic        ack_start;
  logic        push_req;
  logic [15:0] push_addr;
  logic        vec_done;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  halt_wake_ctrl u_halt_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .halt_dec(halt_dec), .pc_next(pc_next),
    .ie(ie), .irq_req(irq_req), .nmi_req(nmi_req), .im_sel(im_sel),
    .halt_n(halt_n), .stat_word(stat_word), .s_code(s_code), .bus_en(bus_en),
    .ack_start(ack_start), .push_req(push_req), .push_addr(push_addr),
    .vec_done(vec_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic enter_halt(input logic [15:0] addr);
    halt_dec = 1'b1;
    pc_next  = addr;
    step();
    halt_dec = 1'b0;
    pc_next  = 16'hFFFF;
    chk(halt_n == 1'b0, "R1 halt_n after halt_dec", halt_n, 0);
    chk(bus_en == 1'b0 && s_code == 2'b00, "R2 bus off/code", {bus_en, s_code}, 0);
  endtask

  task automatic t_wake(input int pre, input logic [1:0] mode, input bit use_nmi,
                        input bit both, input int exp_len, input logic [15:0] addr);
    int n;
    int len;
    int pushes;
    enter_halt(addr);
    repeat (pre) step();
    im_sel  = mode;
    ie      = 1'b1;
    irq_req = !use_nmi || both;
    nmi_req = use_nmi;
    n = 0;
    do begin step(); n++; end while (!ack_start && n < 10);
    chk(n == 4 - pre, "R6 wake delay", n, 4 - pre);
    chk(halt_n == 1'b1, "R7 halt_n high at ack", halt_n, 1);
    chk(push_req == 1'b1, "R8 push at ack", push_req, 1);
    chk(push_addr == addr, "R8 push address", push_addr, addr);
    irq_req = 1'b0;
    nmi_req = 1'b0;
    len = 1;
    pushes = 1;
    while (!vec_done && len < 40) begin
      step(); len++;
      if (push_req) pushes++;
    end
    chk(len == exp_len, both ? "R10 nmi priority length" : "R9 vector length", len, exp_len);
    chk(pushes == 1, "R8 single push", pushes, 1);
    step();
    chk(halt_n == 1'b1 && ack_start == 1'b0, "R12 back to running", halt_n, 1);
  endtask

  task automatic t_reset_state();
    chk(halt_n == 1'b1, "R11 reset halt_n", halt_n, 1);
    chk(bus_en == 1'b1 && s_code == 2'b11, "R2 running bus/code", {bus_en, s_code}, 7);
    chk(stat_word == 8'h00, "R3 running status", stat_word, 0);
  endtask

  task automatic t_status_loop();
    int bad = 0;
    enter_halt(16'h1234);
    for (int i = 0; i < 8; i++) begin
      if (stat_word != ((i % 4 == 0) ? 8'h08 : 8'h00)) bad++;
      step();
    end
    chk(bad == 0, "R3 status bit pattern", bad, 0);
  endtask

  task automatic t_async_reset();
    #1 rst_n = 1'b0;
    #1;
    chk(halt_n == 1'b1, "R11 async halt_n release", halt_n, 1);
    chk(bus_en == 1'b1, "R11 async bus_en", bus_en, 1);
    step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_masked_then_nmi();
    int acks = 0;
    int n;
    enter_halt(16'h0400);
    ie = 1'b0;
    irq_req = 1'b1;
    for (int i = 0; i < 20; i++) begin
      step();
      if (ack_start || halt_n) acks++;
    end
    chk(acks == 0, "R4 masked request ignored", acks, 0);
    chk(halt_n == 1'b0, "R1 still halted", halt_n, 0);
    nmi_req = 1'b1;
    n = 0;
    do begin step(); n++; end while (!ack_start && n < 10);
    chk(ack_start == 1'b1 && n == 4, "R5 nmi wakes with ie=0", n, 4);
    irq_req = 1'b0;
    nmi_req = 1'b0;
    repeat (12) step();
    chk(halt_n == 1'b1, "R5 running after nmi", halt_n, 1);
  endtask

  task automatic t_running_ignores();
    int acks = 0;
    ie = 1'b1; irq_req = 1'b1; nmi_req = 1'b1;
    for (int i = 0; i < 10; i++) begin
      step();
      if (ack_start || push_req || !halt_n) acks++;
    end
    irq_req = 1'b0; nmi_req = 1'b0;
    chk(acks == 0, "R12 no wake while running", acks, 0);
  endtask

  initial begin
    step();
    t_reset_state();
    rst_n = 1'b1;
    step();
    t_running_ignores();
    t_wake(0, 2'd0, 1'b0, 1'b0, 11, 16'h1001);
    t_wake(1, 2'd1, 1'b0, 1'b0, 13, 16'h2002);
    t_wake(2, 2'd2, 1'b0, 1'b0, 19, 16'h3003);
    t_wake(3, 2'd2, 1'b1, 1'b0, 11, 16'h4004);
    t_wake(3, 2'd2, 1'b1, 1'b1, 11, 16'hBEEF);
    t_masked_then_nmi();
    t_status_loop();
    t_async_reset();
    t_reset_state();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule